// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block works out where a fixed-length 32-bit load/store core fetches next. Each cycle it takes the current program counter, a two-bit flow class from the decoder, the 16-bit immediate, the rs1 register index and the value read for that register. From these it produces the next program counter, a taken flag and a request to write a return address into the link register.

A small program-counter register sits inside the block. It moves to the computed next address on each cycle where `advance_i` is high and holds its value otherwise. Conditional branches test one register against zero. The branch offset is added to the address of the following instruction. The return address always goes to register 31.

Top module: `npc_unit`

## Requirements
- R1: The flow class encoding is 2'b00 sequential, 2'b01 branch-if-zero, 2'b10 register jump and 2'b11 register jump with link. For the sequential class, `npc_o` is `pc_o`+4, `taken_o` is low and `link_we_o` is low.
- R2: For branch-if-zero with an effective rs1 value of zero, `taken_o` is high and `npc_o` is `pc_o`+4 plus `imm_i` sign-extended from bit 15.
- R3: For branch-if-zero with a non-zero effective rs1 value, `npc_o` is `pc_o`+4, `taken_o` is low and `link_we_o` is low.
- R4: For a register jump, `npc_o` equals the effective rs1 value, `taken_o` is high and `link_we_o` is low.
- R5: For a jump with link, `npc_o` equals the effective rs1 value and `taken_o` is high. `link_we_o` equals `advance_i`, `link_idx_o` is 31 and `link_data_o` is the pre-update `pc_o`+4, so the jump and the link write take effect on the same edge.
- R6: When `rs1_idx_i` is 0, the effective rs1 value is zero whatever `rs1_val_i` carries. A jump through register 0 goes to address 0, and a branch-if-zero on register 0 is always taken.
- R7: `pc_o` becomes 0 on the first clock edge where `rst` is high.
- R8: `pc_o` loads `npc_o` on a clock edge where `advance_i` is high and `rst` is low, and keeps its value when `advance_i` is low.
- R9: All address sums wrap modulo 2^32, and no other indication is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance_i | input | 1 | Commit the next address into the PC this cycle |
| flow_i | input | 2 | Flow class from the decoder |
| imm_i | input | 16 | Branch offset field |
| rs1_idx_i | input | 5 | Index of the tested or jump-source register |
| rs1_val_i | input | 32 | Value read for that register |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Address the PC takes on the next advance |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Write request for the return address |
| link_idx_o | output | 5 | Destination register of the link write |
| link_data_o | output | 32 | Return address to be written |

## Verification
The assertions assume that `rst` is held high for the first clock edge. They also assume that `flow_i`, `imm_i`, `rs1_idx_i` and `rs1_val_i` are settled before each rising edge, because the next-address checks compare registered PC values with what the combinational outputs showed one edge earlier. The bench changes every input only just after a falling edge and leaves them steady until the next falling edge. It starts with reset asserted at time zero. The zero-register and wrap-around cases use the same timing as every other case.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      FLOW_SEQ   = 2'b00,
      FLOW_BRZ   = 2'b01,
      FLOW_JREG  = 2'b10,
      FLOW_JLINK = 2'b11
   } flow_e;
endpackage

// File: rtl/npc_operand.sv
module npc_operand #(
   parameter int XLEN          = 32,
   parameter int IMM_W         = 16,
   parameter int REG_W         = 5,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic [IMM_W-1:0] imm_i,
   input  logic [REG_W-1:0] idx_i,
   input  logic [XLEN-1:0]  val_i,
   output logic [XLEN-1:0]  src_o,
   output logic [XLEN-1:0]  imm_ext_o
);
   localparam int EXT_W = XLEN - IMM_W;

   assign imm_ext_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

   generate
      if (ZERO_REG_HARD) begin : g_zero_hard
         assign src_o = (idx_i == '0) ? '0 : val_i;
      end else begin : g_zero_soft
         assign src_o = val_i;
      end
   endgenerate

   // R6: register 0 never yields a non-zero operand
   always_comb begin
      if (ZERO_REG_HARD && idx_i == '0)
         a_r6_zero_reg: assert (src_o == '0 || $isunknown(idx_i));
   end
endmodule

// File: rtl/npc_adder.sv
module npc_adder #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] off_i,
   output logic [XLEN-1:0] seq_o,
   output logic [XLEN-1:0] br_o
);
   // both sums truncate to XLEN bits: modulo-2^XLEN wrap (R9)
   assign seq_o = pc_i + XLEN'(INSN_BYTES);
   assign br_o  = seq_o + off_i;
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  flow_e           flow_i,
   input  logic [XLEN-1:0] src_i,
   input  logic [XLEN-1:0] seq_i,
   input  logic [XLEN-1:0] br_i,
   output logic [XLEN-1:0] npc_o,
   output logic            taken_o,
   output logic            link_o
);
   logic src_zero;
   assign src_zero = (src_i == '0);

   always_comb begin
      npc_o   = seq_i;
      taken_o = 1'b0;
      link_o  = 1'b0;
      unique case (flow_i)
         FLOW_SEQ: ;
         FLOW_BRZ: begin
            if (src_zero) begin
               npc_o   = br_i;
               taken_o = 1'b1;
            end
         end
         FLOW_JREG: begin
            npc_o   = src_i;
            taken_o = 1'b1;
         end
         FLOW_JLINK: begin
            npc_o   = src_i;
            taken_o = 1'b1;
            link_o  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int IMM_W         = 16,
   parameter int REG_W         = 5,
   parameter int LINK_REG      = 31,
   parameter int INSN_BYTES    = 4,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             advance_i,
   input  logic [1:0]       flow_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [REG_W-1:0] rs1_idx_i,
   input  logic [XLEN-1:0]  rs1_val_i,
   output logic [XLEN-1:0]  pc_o,
   output logic [XLEN-1:0]  npc_o,
   output logic             taken_o,
   output logic             link_we_o,
   output logic [REG_W-1:0] link_idx_o,
   output logic [XLEN-1:0]  link_data_o
);
   localparam int NREGS = 1 << REG_W;

   generate
      if (IMM_W < 2 || IMM_W > XLEN) begin : g_bad_imm
         $error("npc_unit: IMM_W must lie in 2..XLEN");
      end
      if (LINK_REG < 1 || LINK_REG >= NREGS) begin : g_bad_link
         $error("npc_unit: LINK_REG outside register file");
      end
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("npc_unit: INSN_BYTES must be positive");
      end
   endgenerate

   flow_e           flow;
   logic [XLEN-1:0] src_val, imm_ext, seq_pc, br_pc, nxt;
   logic            link_req, tk;
   logic [XLEN-1:0] pc_q;

   assign flow = flow_e'(flow_i);

   npc_operand #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W),
                 .ZERO_REG_HARD(ZERO_REG_HARD)) u_operand (
      .imm_i(imm_i), .idx_i(rs1_idx_i), .val_i(rs1_val_i),
      .src_o(src_val), .imm_ext_o(imm_ext));

   npc_adder #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_adder (
      .pc_i(pc_q), .off_i(imm_ext), .seq_o(seq_pc), .br_o(br_pc));

   npc_select #(.XLEN(XLEN)) u_select (
      .flow_i(flow), .src_i(src_val), .seq_i(seq_pc), .br_i(br_pc),
      .npc_o(nxt), .taken_o(tk), .link_o(link_req));

   always_ff @(posedge clk) begin
      if (rst)            pc_q <= '0;
      else if (advance_i) pc_q <= nxt;
   end

   assign pc_o        = pc_q;
   assign npc_o       = nxt;
   assign taken_o     = tk;
   assign link_we_o   = link_req & advance_i;
   assign link_idx_o  = REG_W'(LINK_REG);
   assign link_data_o = seq_pc;

   a_r7_reset_pc: assert property (@(posedge clk) rst |=> pc_q == '0);

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !advance_i |=> $stable(pc_q));

   a_r8_load: assert property (@(posedge clk) disable iff (rst)
      advance_i |=> pc_q == $past(nxt));

   a_r1_seq_quiet: assert property (@(posedge clk) disable iff (rst)
      flow == FLOW_SEQ |-> !tk && !link_we_o);

   a_r3_not_taken: assert property (@(posedge clk) disable iff (rst)
      (flow == FLOW_BRZ && src_val != '0) |-> !tk && nxt == seq_pc);

   a_r4_jump_target: assert property (@(posedge clk) disable iff (rst)
      (flow == FLOW_JREG || flow == FLOW_JLINK) |-> tk && nxt == src_val);

   a_r5_link_edge: assert property (@(posedge clk) disable iff (rst)
      link_we_o |=> pc_q == $past(src_val) && $past(link_data_o) == $past(pc_q) + XLEN'(INSN_BYTES));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        advance_i = 1'b0;
   logic [1:0]  flow_i = 2'b00;
   logic [15:0] imm_i = '0;
   logic [4:0]  rs1_idx_i = '0;
   logic [31:0] rs1_val_i = '0;
   logic [31:0] pc_o, npc_o, link_data_o;
   logic        taken_o, link_we_o;
   logic [4:0]  link_idx_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   npc_unit u_npc_unit (
      .clk(clk), .rst(rst), .advance_i(advance_i), .flow_i(flow_i),
      .imm_i(imm_i), .rs1_idx_i(rs1_idx_i), .rs1_val_i(rs1_val_i),
      .pc_o(pc_o), .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
      .link_idx_o(link_idx_o), .link_data_o(link_data_o));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive after a falling edge, let comb settle
   task automatic drive(input logic [1:0] fl, input logic [15:0] im,
                        input logic [4:0] ix, input logic [31:0] v, input logic adv);
      @(negedge clk);
      flow_i = fl; imm_i = im; rs1_idx_i = ix; rs1_val_i = v; advance_i = adv;
      #1;
   endtask

   task automatic commit;
      @(posedge clk); #1;
   endtask

   task automatic set_pc(input logic [31:0] a);
      drive(2'b10, 16'h0, 5'd7, a, 1'b1);
      commit();
   endtask

   task automatic t_reset;
      chk("R7", "pc after reset", pc_o, 32'h0);
   endtask

   task automatic t_seq;
      set_pc(32'h0000_1000);
      drive(2'b00, 16'h1234, 5'd3, 32'h0, 1'b1);
      chk("R1", "seq npc", npc_o, 32'h0000_1004);
      chk("R1", "seq taken", {31'b0, taken_o}, 32'h0);
      chk("R1", "seq link", {31'b0, link_we_o}, 32'h0);
      commit();
      chk("R8", "pc after seq advance", pc_o, 32'h0000_1004);
   endtask

   task automatic t_brz;
      set_pc(32'h0000_0100);
      drive(2'b01, 16'hFFF0, 5'd4, 32'h0, 1'b1);
      chk("R2", "brz back npc", npc_o, 32'h0000_00F4);
      chk("R2", "brz taken", {31'b0, taken_o}, 32'h1);
      commit();
      chk("R2", "pc after back branch", pc_o, 32'h0000_00F4);
      drive(2'b01, 16'h0040, 5'd4, 32'h0, 1'b0);
      chk("R2", "brz fwd npc", npc_o, 32'h0000_0138);
      drive(2'b01, 16'h0040, 5'd4, 32'h0000_0001, 1'b1);
      chk("R3", "brz not taken npc", npc_o, 32'h0000_00F8);
      chk("R3", "brz not taken flag", {31'b0, taken_o}, 32'h0);
      chk("R3", "brz no link", {31'b0, link_we_o}, 32'h0);
      commit();
      chk("R3", "pc after fallthrough", pc_o, 32'h0000_00F8);
   endtask

   task automatic t_jumps;
      set_pc(32'h0000_2000);
      drive(2'b10, 16'h0, 5'd9, 32'hDEAD_BEE0, 1'b1);
      chk("R4", "jr npc", npc_o, 32'hDEAD_BEE0);
      chk("R4", "jr taken", {31'b0, taken_o}, 32'h1);
      chk("R4", "jr no link", {31'b0, link_we_o}, 32'h0);
      commit();
      chk("R4", "pc after jr", pc_o, 32'hDEAD_BEE0);
      drive(2'b11, 16'h0, 5'd12, 32'h0000_4000, 1'b1);
      chk("R5", "jalr npc", npc_o, 32'h0000_4000);
      chk("R5", "jalr link we", {31'b0, link_we_o}, 32'h1);
      chk("R5", "jalr link idx", {27'b0, link_idx_o}, 32'd31);
      chk("R5", "jalr link data", link_data_o, 32'hDEAD_BEE4);
      commit();
      chk("R5", "pc after jalr", pc_o, 32'h0000_4000);
      drive(2'b11, 16'h0, 5'd12, 32'h0000_8000, 1'b0);
      chk("R5", "jalr link gated by advance", {31'b0, link_we_o}, 32'h0);
   endtask

   task automatic t_zero_reg;
      set_pc(32'h0000_3000);
      drive(2'b10, 16'h0, 5'd0, 32'hFFFF_FFFF, 1'b1);
      chk("R6", "jr r0 npc", npc_o, 32'h0);
      commit();
      chk("R6", "pc after jr r0", pc_o, 32'h0);
      drive(2'b01, 16'h0010, 5'd0, 32'h1234_5678, 1'b0);
      chk("R6", "brz r0 taken", {31'b0, taken_o}, 32'h1);
      chk("R6", "brz r0 npc", npc_o, 32'h0000_0014);
   endtask

   task automatic t_hold;
      set_pc(32'h0000_5000);
      drive(2'b10, 16'h0, 5'd2, 32'h0000_9999, 1'b0);
      commit();
      chk("R8", "pc held without advance", pc_o, 32'h0000_5000);
      commit();
      chk("R8", "pc still held", pc_o, 32'h0000_5000);
   endtask

   task automatic t_wrap;
      set_pc(32'hFFFF_FFFC);
      drive(2'b00, 16'h0, 5'd1, 32'h0, 1'b1);
      chk("R9", "seq wrap npc", npc_o, 32'h0);
      chk("R9", "jalr-free wrap link data", link_data_o, 32'h0);
      commit();
      chk("R9", "pc wrapped", pc_o, 32'h0);
      set_pc(32'hFFFF_FFF0);
      drive(2'b01, 16'h0020, 5'd1, 32'h0, 1'b1);
      chk("R9", "branch wrap npc", npc_o, 32'h0000_0014);
   endtask

   task automatic t_sync_reset;
      set_pc(32'h0000_7000);
      @(negedge clk); rst = 1'b1; advance_i = 1'b0;
      #1;
      chk("R7", "reset is synchronous", pc_o, 32'h0000_7000);
      commit();
      chk("R7", "pc cleared on edge", pc_o, 32'h0);
      @(negedge clk); rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      @(posedge clk); #1;
      @(negedge clk); rst = 1'b0;
      t_reset();
      t_seq();
      t_brz();
      t_jumps();
      t_zero_reg();
      t_hold();
      t_wrap();
      t_sync_reset();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule